// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Core

This block holds a small programmable two-level logic array. Six external signals are each presented to the array twice, once as they are and once inverted, which gives twelve literal lines. Sixteen product terms each see all twelve lines, and one stored connection bit per crossing decides whether that line takes part in the term. A connected crossing lets the line through to the AND. A disconnected crossing feeds a constant 1, so that line has no effect on the term. The four outputs each OR a fixed, private group of four consecutive product terms. Terms cannot be moved to another output.

The 192 connection bits sit in a shift register that is loaded one bit per clock through a serial configuration port. Reset puts every crossing in the connected state, which is the erased state. In that state every term ANDs each signal with its own complement, so all outputs are 0 until the array is programmed. Once loaded, the outputs follow the inputs combinationally. To switch off an unused term, leave all of its crossings connected.

Top module: `sop_array`

## Requirements
- R1: The literal lines are numbered 0 to 11. Line 2i carries sig_in[i] and line 2i+1 carries its complement, for i = 0..5.
- R2: Connection bit k = 12*t + l belongs to product term t and literal line l, and a value of 1 means connected. Each clock with cfg_shift high moves the store one place toward bit 0 and writes cfg_bit into bit 191. The first of 192 shifted bits therefore lands in bit 0.
- R3: While cfg_shift is low, the stored configuration does not change whatever cfg_bit does, so the outputs stay the same function of sig_in.
- R4: While rst_n is low, and after it, every connection bit is 1 (erased), so sum_out is 0 for every input value until programming.
- R5: A product term is 1 exactly when every connected literal line is 1. A disconnected crossing contributes a constant 1.
- R6: A term whose twelve crossings are all connected, or that connects any signal together with its complement, is always 0.
- R7: A term with no connected crossing is always 1, which drives its output to constant 1.
- R8: sum_out[o] is the OR of terms 4o to 4o+3 only. A term never affects any other output.
- R9: sum_out responds to sig_in within the same cycle, with no clock edge needed, once the configuration is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Asynchronous active-low reset; erases the array |
| cfg_shift | input | 1 | Shift enable for the configuration store |
| cfg_bit | input | 1 | Serial configuration data |
| sig_in | input | 6 | External logic inputs |
| sum_out | output | 4 | Sum-of-products outputs |

## Verification
The assertions check the following on every cycle: the store either holds or shifts by exactly one place with cfg_bit entering at the top; any term that is fully connected, or that connects a signal together with its complement, reads 0; an output is never 1 while all four of its own terms are 0; and the outputs are 0 on the cycle reset is released. The bench scenarios are needed for the rest. They show that the serial bit order places each bit on the intended term and line, that loaded equations produce the right truth tables over all 64 input values, that an unconnected term forces its output high without reaching any other output, and that toggling cfg_bit with the shift disabled leaves the function unchanged.

// File: rtl/sop_pkg.sv
package sop_pkg;
  parameter int N_IN  = 6;
  parameter int N_OUT = 4;
  parameter int TPO   = 4;

  // Value of one literal line: even lines true, odd lines inverted.
  function automatic logic line_value(input logic [N_IN-1:0] x, input int line);
    logic v;
    v = x[line / 2];
    return (line % 2 == 1) ? ~v : v;
  endfunction

  // Mask of signals whose true and inverted crossings are both connected.
  function automatic logic [N_IN-1:0] pair_clash(input logic [2*N_IN-1:0] conn);
    logic [N_IN-1:0] m;
    for (int i = 0; i < N_IN; i++) m[i] = conn[2*i] & conn[2*i+1];
    return m;
  endfunction
endpackage

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int W = 192
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '1;
    else if (shift_en) cfg_q <= {din, cfg_q[W-1:1]};
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(cfg_q)); // R3

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (cfg_q[W-2:0] == $past(cfg_q[W-1:1])) && (cfg_q[W-1] == $past(din))); // R2
endmodule

// File: rtl/term_plane.sv
module term_plane
  import sop_pkg::*;
#(
  parameter int NI = 6,
  parameter int NT = 16,
  localparam int NL = 2 * NI
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NI-1:0]   sig_in,
  input  logic [NT*NL-1:0] conn,
  output logic [NT-1:0]   terms
);
  logic [NL-1:0] lines;

  for (genvar l = 0; l < NL; l++) begin : g_line
    if (l % 2 == 0) begin : g_true
      assign lines[l] = sig_in[l/2];
    end else begin : g_inv
      assign lines[l] = ~sig_in[l/2];
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_term
    logic [NL-1:0] c_t;
    logic          all_conn;
    logic          clash;
    assign c_t      = conn[t*NL +: NL];
    // Disconnected crossing behaves as constant 1.
    assign terms[t] = &(lines | ~c_t);
    assign all_conn = &c_t;
    assign clash    = |pair_clash(c_t);

    AST_ERASED_TERM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      all_conn |-> !terms[t]); // R6
    AST_CLASH_TERM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clash |-> !terms[t]); // R6
    AST_OPEN_TERM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (c_t == '0) |-> terms[t]); // R7
  end
endmodule

// File: rtl/or_group.sv
module or_group #(
  parameter int NO  = 4,
  parameter int TPO = 4,
  localparam int NT = NO * TPO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] terms,
  output logic [NO-1:0] sums
);
  for (genvar o = 0; o < NO; o++) begin : g_out
    logic [TPO-1:0] grp;
    assign grp     = terms[o*TPO +: TPO];
    assign sums[o] = |grp;

    AST_OUT_NEEDS_OWN_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(grp) == 0) |-> !sums[o]); // R8
  end
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
#(
  parameter int NI  = sop_pkg::N_IN,
  parameter int NO  = sop_pkg::N_OUT,
  parameter int TP  = sop_pkg::TPO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_shift,
  input  logic          cfg_bit,
  input  logic [NI-1:0] sig_in,
  output logic [NO-1:0] sum_out
);
  localparam int NL = 2 * NI;
  localparam int NT = NO * TP;
  localparam int W  = NT * NL;

  logic [W-1:0]  cfg_q;
  logic [NT-1:0] terms;

  cfg_store #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .shift_en(cfg_shift), .din(cfg_bit), .cfg_q(cfg_q)
  );

  term_plane #(.NI(NI), .NT(NT)) u_plane (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .conn(cfg_q), .terms(terms)
  );

  or_group #(.NO(NO), .TPO(TP)) u_or (
    .clk(clk), .rst_n(rst_n), .terms(terms), .sums(sum_out)
  );

  AST_RESET_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sum_out == '0)); // R4
endmodule

// File: tb/sim_sop_array.sv
module sim_sop_array;
  localparam int W = 192;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_shift = 1'b0;
  logic       cfg_bit = 1'b0;
  logic [5:0] sig_in = '0;
  logic [3:0] sum_out;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sop_array u0 (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
    .sig_in(sig_in), .sum_out(sum_out)
  );

  task automatic check(input string req, input logic [5:0] x,
                       input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s in=%b actual=%b expected=%b", req, x, act, exp);
    end
  endtask

  // Reference: literal 2i = x[i], 2i+1 = ~x[i]; bit 12t+l, 1 = connected.
  function automatic logic [3:0] model(input logic [W-1:0] c, input logic [5:0] x);
    logic [3:0] o;
    o = '0;
    for (int t = 0; t < 16; t++) begin
      logic p;
      p = 1'b1;
      for (int l = 0; l < 12; l++) begin
        logic lv;
        lv = (l % 2 == 1) ? !x[l/2] : x[l/2];
        if (c[t*12+l] && !lv) p = 1'b0;
      end
      if (p) o[t/4] = 1'b1;
    end
    return o;
  endfunction

  function automatic logic [W-1:0] put_term(input logic [W-1:0] c, input int t,
                                            input logic [5:0] pos, input logic [5:0] neg);
    logic [W-1:0] r;
    r = c;
    for (int i = 0; i < 6; i++) begin
      r[t*12+2*i]   = pos[i];
      r[t*12+2*i+1] = neg[i];
    end
    return r;
  endfunction

  task automatic load(input logic [W-1:0] c);
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      cfg_shift = 1'b1;
      cfg_bit   = c[k];
    end
    @(negedge clk);
    cfg_shift = 1'b0;
  endtask

  task automatic sweep_model(input string req, input logic [W-1:0] c);
    @(negedge clk);
    for (int v = 0; v < 64; v++) begin
      sig_in = v[5:0];
      #1;
      check(req, sig_in, sum_out, model(c, sig_in));
    end
  endtask

  task automatic sweep_const(input string req, input logic [3:0] exp);
    @(negedge clk);
    for (int v = 0; v < 64; v++) begin
      sig_in = v[5:0];
      #1;
      check(req, sig_in, sum_out, exp);
    end
  endtask

  // Known equations, computed directly from Boolean formulas.
  task automatic sweep_eq(input string req);
    @(negedge clk);
    for (int v = 0; v < 64; v++) begin
      logic [5:0] x;
      logic [3:0] e;
      x = v[5:0];
      e[0] = (x[0] & x[1] & x[2]) | (~x[1] & ~x[2] & x[3]) | (x[0] & x[3]);
      e[1] = x[4] ^ x[5];
      e[2] = ~x[0];
      e[3] = 1'b1;
      sig_in = x;
      #1;
      check(req, x, sum_out, e);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] erased;
    logic [W-1:0] eq;
    logic [W-1:0] c;
    erased = '1;

    // R4: reset state reads 0 for all inputs, even with reset held
    repeat (3) @(negedge clk);
    sweep_const("R4 during reset", 4'b0000);
    rst_n = 1'b1;
    sweep_const("R4 after reset", 4'b0000);

    // R1 R2 R5 R7 R9: known equations, order of shifted bits matters
    eq = erased;
    eq = put_term(eq, 0,  6'b000111, 6'b000000);
    eq = put_term(eq, 1,  6'b001000, 6'b000110);
    eq = put_term(eq, 2,  6'b001001, 6'b000000);
    eq = put_term(eq, 4,  6'b010000, 6'b100000);
    eq = put_term(eq, 5,  6'b100000, 6'b010000);
    eq = put_term(eq, 8,  6'b000000, 6'b000001);
    eq = put_term(eq, 12, 6'b000000, 6'b000000);
    load(eq);
    sweep_eq("R1 R2 R5 R7 R9 equations");

    // R3: cfg_bit toggles with shift disabled; function unchanged
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cfg_bit = k[0];
    end
    sweep_eq("R3 hold with shift low");

    // R8: one open term in group 1 drives only output 1
    load(put_term(erased, 4, 6'b0, 6'b0));
    sweep_const("R8 no sharing", 4'b0010);

    // R6: term 0 connects x2 and ~x2; term 12 open proves the load landed
    c = put_term(erased, 0, 6'b000100, 6'b000100);
    c = put_term(c, 12, 6'b0, 6'b0);
    load(c);
    sweep_const("R6 complement pair", 4'b1000);

    // R5 R2: several random non-clashing configurations against the model
    for (int r = 0; r < 4; r++) begin
      c = erased;
      for (int t = 0; t < 16; t++) begin
        logic [5:0] p;
        logic [5:0] n;
        p = 6'($urandom) & 6'($urandom);
        n = 6'($urandom) & 6'($urandom) & ~p;
        if (($urandom % 4) != 0) c = put_term(c, t, p, n);
      end
      load(c);
      sweep_model("R5 random config", c);
    end

    // R6: all-connected terms everywhere again gives 0; then reset erases
    load(erased);
    sweep_const("R6 all connected", 4'b0000);
    load(eq);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    sweep_const("R4 re-reset erases", 4'b0000);

    summary();
    $finish;
  end
endmodule